// File: doc/BRIEF.md
# Low-Power Sleep and Wake Sequencer

This block sits beside a small processor core and manages what happens when the core executes its sleep instruction. At that moment it samples two mode-select bits and an I/O stop bit and picks one of three low-power modes: light sleep, idle or standby. It then gates the core clock, and in the deeper modes also the clock output pin. The oscillator input keeps running throughout. The block watches for wake sources: synchronous reset, bus request, maskable interrupt levels qualified by per-source enables, and a falling edge on the active-low non-maskable interrupt, which it holds in a latch.

In idle and standby, a wake event first starts a restart down-counter. The fixed parameter `IDLE_DELAY` sets the count in idle, and the `restart_cnt` input sets it in standby. The clocks are released only when the count is exhausted. At that point the block checks the wake condition again. A maskable level that has gone away sends the block back to sleep. A latched NMI always resumes the core. On resume the block raises a one-cycle pulse: `wake_ack` means the core must run an interrupt acknowledge, and `wake_cont` means it carries on after the sleep instruction. The global interrupt enable decides which pulse a maskable wake produces. A bus request wakes only the bus-grant path. The core stays gated and goes back to sleep when the request is removed.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, `core_en` and `clkout_en` are 1 and `bus_grant`, `wake_ack`, `wake_cont` and `wake_nmi` are 0.
- R2: On `sleep_exec` the mode is decoded from (`sel_hi`, `sel_lo`, `io_stop`). Idle is `sel_hi`=0, `sel_lo`=1, `io_stop`=1. Standby is `sel_hi`=1, `sel_lo`=1. Every other code is light sleep. All modes drop `core_en`. Only idle and standby also drop `clkout_en`, and `clkout_en` is never 0 while `core_en` is 1.
- R3: In light sleep, a wake sampled at a clock edge raises `core_en` and `clkout_en` at that same edge, with no restart delay.
- R4: In idle, or in standby, a wake sampled at edge j restarts the clocks at edge j+D+1. D is `IDLE_DELAY` in idle and `restart_cnt` in standby.
- R5: A maskable wake gives a one-cycle `wake_ack` when `int_en_all`=1 and a one-cycle `wake_cont` when it is 0. An NMI wake always gives `wake_ack` together with `wake_nmi`=1. The pulse coincides with the rise of `core_en`.
- R6: Only an interrupt source i with both `irq_req[i]`=1 and `irq_en[i]`=1 wakes the block. Any other combination leaves `core_en` at 0.
- R7: If no enabled maskable level is present when the restart count expires, the block returns to sleep. `core_en` stays 0, no pulse is issued, and a later wake behaves as in R4.
- R8: A single-cycle low pulse on `nmi_n` during sleep is latched. It wakes the block after the restart delay even though `nmi_n` is high again by then.
- R9: In sleep, `bus_req` raises `bus_grant` at the next edge while `core_en` stays 0. Removing `bus_req` clears `bus_grant` at the next edge and returns to sleep. A wake that arrived during the grant is then taken at the following edge.
- R10: Reset during sleep or during the restart count restores `core_en`=1 at the next edge without any delay or pulse, and clears the NMI latch.
- R11: `core_clk` and `clk_out` are `clk` ANDed with the matching enable, which is captured on the falling edge of `clk`. They are low through every high phase of `clk` while the enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Synchronous active-high reset, highest-priority wake |
| sleep_exec | input | 1 | One-cycle strobe: core executes the sleep instruction |
| sel_hi | input | 1 | Upper mode-select bit |
| sel_lo | input | 1 | Lower mode-select bit |
| io_stop | input | 1 | I/O stop bit |
| int_en_all | input | 1 | Global maskable interrupt enable |
| irq_req | input | N_IRQ | Maskable interrupt levels, active high |
| irq_en | input | N_IRQ | Per-source interrupt enables |
| nmi_n | input | 1 | Non-maskable interrupt, active low, edge sensitive |
| bus_req | input | 1 | External bus request |
| restart_cnt | input | CNT_W | Standby restart count |
| core_en | output | 1 | Registered core clock enable |
| clkout_en | output | 1 | Registered clock-output enable |
| core_clk | output | 1 | Gated core clock |
| clk_out | output | 1 | Gated clock output |
| bus_grant | output | 1 | Bus granted while asleep |
| wake_ack | output | 1 | Pulse: run interrupt acknowledge |
| wake_cont | output | 1 | Pulse: continue after sleep instruction |
| wake_nmi | output | 1 | Pulse: the wake was caused by NMI |

## Verification
The bench builds the block with three interrupt sources, a 4-bit restart count and `IDLE_DELAY`=3. With these values every restart count from 0 to 15 can be swept in standby under both global-enable settings. All eight select codes can be decoded, and every enable mask can be paired with every single requesting source. Wake latency is measured in cycles and compared with D+2 falling edges from the wake stimulus to the enable rising. That exposes any off-by-one in the counter. The short counts also keep the cases where a level vanishes, an NMI pulse is latched, a bus grant is interleaved and a reset interrupts the count all cheap to reach.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {PM_RUN, PM_SLEEP, PM_WAIT, PM_BUS} pm_state_t;
  typedef enum logic [1:0] {LP_LIGHT, LP_IDLE, LP_STBY} lp_mode_t;
endpackage

// File: rtl/lpm_mode_dec.sv
module lpm_mode_dec
  import lpm_pkg::*;
(
  input  logic     sel_hi,
  input  logic     sel_lo,
  input  logic     io_stop,
  output lp_mode_t mode
);
  always_comb begin
    if (sel_lo && sel_hi)         mode = LP_STBY;
    else if (sel_lo && io_stop)   mode = LP_IDLE;
    else                          mode = LP_LIGHT;
  end
endmodule

// File: rtl/lpm_restart_timer.sv
module lpm_restart_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R4: once expired, the count stays at zero until reloaded
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && zero) |=> zero);
endmodule

// File: rtl/lpm_clk_gate.sv
module lpm_clk_gate (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic gclk
);
  logic en_q;

  // enable captured while clk is low so the gated clock cannot glitch
  always_ff @(negedge clk) begin
    if (rst) en_q <= 1'b1;
    else     en_q <= en;
  end

  assign gclk = clk & en_q;

  assert_gate_track_R11: assert property (@(posedge clk) disable iff (rst)
    en_q == en);
endmodule

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl
  import lpm_pkg::*;
#(
  parameter int N_IRQ      = 3,
  parameter int CNT_W      = 4,
  parameter int IDLE_DELAY = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_exec,
  input  logic             sel_hi,
  input  logic             sel_lo,
  input  logic             io_stop,
  input  logic             int_en_all,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             nmi_n,
  input  logic             bus_req,
  input  logic [CNT_W-1:0] restart_cnt,
  output logic             core_en,
  output logic             clkout_en,
  output logic             core_clk,
  output logic             clk_out,
  output logic             bus_grant,
  output logic             wake_ack,
  output logic             wake_cont,
  output logic             wake_nmi
);
  localparam logic [CNT_W-1:0] IDLE_LD = CNT_W'(IDLE_DELAY);
  localparam int N_GATE = 2;

  pm_state_t state;
  lp_mode_t  dec_mode, mode_q;
  logic nmi_q, nmi_lat, nmi_fall, nmi_any, lvl_wake, any_wake;
  logic tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic [N_GATE-1:0] gate_en, gate_clk;

  lpm_mode_dec u_dec (
    .sel_hi (sel_hi),
    .sel_lo (sel_lo),
    .io_stop(io_stop),
    .mode   (dec_mode)
  );

  assign lvl_wake = |(irq_req & irq_en);
  assign nmi_fall = nmi_q & ~nmi_n;
  assign nmi_any  = nmi_lat | nmi_fall;
  assign any_wake = lvl_wake | nmi_any;
  assign tmr_load = (state == PM_SLEEP) && any_wake && (mode_q != LP_LIGHT);
  assign tmr_val  = (mode_q == LP_IDLE) ? IDLE_LD : restart_cnt;

  lpm_restart_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .zero    (tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PM_RUN;
      mode_q    <= LP_LIGHT;
      core_en   <= 1'b1;
      clkout_en <= 1'b1;
      bus_grant <= 1'b0;
      wake_ack  <= 1'b0;
      wake_cont <= 1'b0;
      wake_nmi  <= 1'b0;
      nmi_lat   <= 1'b0;
      nmi_q     <= 1'b1;
    end else begin
      nmi_q     <= nmi_n;
      wake_ack  <= 1'b0;
      wake_cont <= 1'b0;
      wake_nmi  <= 1'b0;
      if (state != PM_RUN && nmi_fall) nmi_lat <= 1'b1;
      case (state)
        PM_RUN: begin
          if (sleep_exec) begin
            mode_q    <= dec_mode;
            state     <= PM_SLEEP;
            core_en   <= 1'b0;
            clkout_en <= (dec_mode == LP_LIGHT);
          end
        end
        PM_SLEEP: begin
          if (any_wake) begin
            if (mode_q == LP_LIGHT) begin
              state     <= PM_RUN;
              core_en   <= 1'b1;
              clkout_en <= 1'b1;
              nmi_lat   <= 1'b0;
              wake_nmi  <= nmi_any;
              wake_ack  <= nmi_any | int_en_all;
              wake_cont <= !nmi_any && !int_en_all;
            end else begin
              state <= PM_WAIT;
            end
          end else if (bus_req) begin
            state     <= PM_BUS;
            bus_grant <= 1'b1;
          end
        end
        PM_WAIT: begin
          if (tmr_zero) begin
            if (any_wake) begin
              state     <= PM_RUN;
              core_en   <= 1'b1;
              clkout_en <= 1'b1;
              nmi_lat   <= 1'b0;
              wake_nmi  <= nmi_any;
              wake_ack  <= nmi_any | int_en_all;
              wake_cont <= !nmi_any && !int_en_all;
            end else begin
              state <= PM_SLEEP;
            end
          end
        end
        default: begin
          if (!bus_req) begin
            bus_grant <= 1'b0;
            state     <= PM_SLEEP;
          end
        end
      endcase
    end
  end

  assign gate_en = {clkout_en, core_en};

  genvar g;
  generate
    for (g = 0; g < N_GATE; g++) begin : g_gate
      lpm_clk_gate u_gate (
        .clk (clk),
        .rst (rst),
        .en  (gate_en[g]),
        .gclk(gate_clk[g])
      );
    end
  endgenerate

  assign core_clk = gate_clk[0];
  assign clk_out  = gate_clk[1];

  assert_reset_run_R1: assert property (@(posedge clk)
    rst |=> (core_en && clkout_en && !bus_grant && !wake_ack && !wake_cont));
  assert_clkout_order_R2: assert property (@(posedge clk) disable iff (rst)
    !clkout_en |-> !core_en);
  assert_pulse_on_resume_R3: assert property (@(posedge clk) disable iff (rst)
    (wake_ack || wake_cont) |-> $rose(core_en));
  assert_one_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wake_ack, wake_cont}));
  assert_nmi_acks_R5: assert property (@(posedge clk) disable iff (rst)
    wake_nmi |-> wake_ack);
  assert_grant_gated_R9: assert property (@(posedge clk) disable iff (rst)
    bus_grant |-> !core_en);
endmodule

// File: tb/lpm_wake_ctrl_test.sv
`timescale 1ns/1ps
module lpm_wake_ctrl_test;
  localparam int N_IRQ = 3;
  localparam int CNT_W = 4;
  localparam int IDLE_D = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_exec = 0, sel_hi = 0, sel_lo = 0, io_stop = 0, int_en_all = 0;
  logic [N_IRQ-1:0] irq_req = '0, irq_en = '0;
  logic nmi_n = 1'b1, bus_req = 1'b0;
  logic [CNT_W-1:0] restart_cnt = '0;
  logic core_en, clkout_en, core_clk, clk_out, bus_grant, wake_ack, wake_cont, wake_nmi;

  int nchk = 0, nerr = 0, npulse = 0;
  logic seen_ack, seen_cont, seen_nmi;

  always #2 clk = ~clk;

  lpm_wake_ctrl #(.N_IRQ(N_IRQ), .CNT_W(CNT_W), .IDLE_DELAY(IDLE_D)) uut (
    .clk(clk), .rst(rst), .sleep_exec(sleep_exec), .sel_hi(sel_hi), .sel_lo(sel_lo),
    .io_stop(io_stop), .int_en_all(int_en_all), .irq_req(irq_req), .irq_en(irq_en),
    .nmi_n(nmi_n), .bus_req(bus_req), .restart_cnt(restart_cnt), .core_en(core_en),
    .clkout_en(clkout_en), .core_clk(core_clk), .clk_out(clk_out), .bus_grant(bus_grant),
    .wake_ack(wake_ack), .wake_cont(wake_cont), .wake_nmi(wake_nmi));

  always @(negedge clk) if (!rst && (wake_ack || wake_cont)) npulse++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic go_sleep(input bit h, input bit l, input bit s);
    @(negedge clk);
    sel_hi = h; sel_lo = l; io_stop = s; sleep_exec = 1'b1;
    @(negedge clk) sleep_exec = 1'b0;
  endtask

  // counts falling edges until core_en is seen high; -1 if none within limit
  task automatic wait_wake(output int n);
    n = -1;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (core_en) begin
        n = k;
        seen_ack = wake_ack; seen_cont = wake_cont; seen_nmi = wake_nmi;
        break;
      end
    end
  endtask

  initial begin
    #(4 * 200000);
    nerr++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int n, exp_n, p0;
    @(negedge clk);
    // R1: reset state
    chk(core_en && clkout_en && !bus_grant && !wake_ack && !wake_cont && !wake_nmi,
        "R1 reset outputs", {core_en, clkout_en, bus_grant, wake_ack, wake_cont}, 5'b11000);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(core_en && clkout_en, "R1 after reset", {core_en, clkout_en}, 2'b11);

    // R2/R3/R4/R11: every select code, wake via enabled source 0
    irq_en = 3'b001; int_en_all = 1'b1; restart_cnt = 4'd2;
    for (int c = 0; c < 8; c++) begin
      bit h, l, s, light;
      h = c[2]; l = c[1]; s = c[0];
      light = !(l && (h || s));
      go_sleep(h, l, s);
      chk(!core_en, "R2 core gated", core_en, 0);
      chk(clkout_en == light, "R2 clkout mode", clkout_en, light);
      @(posedge clk); #1;
      chk(core_clk == 1'b0, "R11 core clock held low", core_clk, 0);
      chk(clk_out == light, "R11 clock output", clk_out, light);
      @(negedge clk);
      irq_req = 3'b001;
      wait_wake(n);
      exp_n = light ? 1 : ((h && l) ? 4 : IDLE_D + 2);
      chk(n == exp_n, light ? "R3 light latency" : "R4 deep latency", n, exp_n);
      chk(seen_ack && !seen_cont, "R5 ack with enable", seen_ack, 1);
      irq_req = '0;
      @(posedge clk); #1;
      chk(core_clk && clk_out, "R11 clocks running", {core_clk, clk_out}, 2'b11);
      @(negedge clk);
    end

    // R4/R5: standby count sweep under both global-enable settings
    for (int d = 0; d < 16; d++) begin
      for (int e = 0; e < 2; e++) begin
        restart_cnt = d[CNT_W-1:0]; int_en_all = e[0];
        go_sleep(1, 1, 0);
        irq_req = 3'b001;
        wait_wake(n);
        chk(n == d + 2, "R4 standby latency", n, d + 2);
        chk(seen_ack == e[0] && seen_cont == !e[0] && !seen_nmi, "R5 pulse kind",
            {seen_ack, seen_cont}, e[0] ? 2 : 1);
        irq_req = '0;
      end
    end

    // R6: enable masks against single requesting sources (light sleep)
    int_en_all = 1'b1;
    for (int m = 0; m < 8; m++) begin
      for (int i = 0; i < N_IRQ; i++) begin
        irq_en = m[N_IRQ-1:0];
        go_sleep(0, 0, 0);
        irq_req = '0; irq_req[i] = 1'b1;
        if (m[i]) begin
          wait_wake(n);
          chk(n == 1, "R6 enabled source wakes", n, 1);
          irq_req = '0;
        end else begin
          repeat (6) @(negedge clk);
          chk(!core_en, "R6 masked source ignored", core_en, 0);
          irq_req = '0;
          do_reset();
          chk(core_en && clkout_en, "R10 reset from sleep", {core_en, clkout_en}, 2'b11);
        end
      end
    end

    // R7: level removed before count expiry
    irq_en = 3'b111; restart_cnt = 4'd4; int_en_all = 1'b0;
    go_sleep(1, 1, 0);
    p0 = npulse;
    irq_req = 3'b010;
    @(negedge clk) irq_req = '0;
    repeat (10) @(negedge clk);
    chk(!core_en && npulse == p0, "R7 vanished level stays asleep", core_en, 0);
    irq_req = 3'b010;
    wait_wake(n);
    chk(n == 6, "R7 later wake still works", n, 6);
    chk(seen_cont, "R5 continue with enable off", seen_cont, 1);
    irq_req = '0;

    // R8: short NMI pulse latched through the count, global enable off
    restart_cnt = 4'd5;
    go_sleep(1, 1, 0);
    nmi_n = 1'b0;
    @(negedge clk) nmi_n = 1'b1;
    wait_wake(n);
    chk(n == 6, "R8 nmi latency", n, 6);
    chk(seen_ack && seen_nmi && !seen_cont, "R8 nmi acknowledged", {seen_ack, seen_nmi}, 3);

    // R9: bus grant while asleep
    irq_en = 3'b001; int_en_all = 1'b1;
    go_sleep(0, 0, 0);
    bus_req = 1'b1;
    @(negedge clk);
    chk(bus_grant && !core_en, "R9 grant while gated", bus_grant, 1);
    repeat (3) @(negedge clk);
    bus_req = 1'b0;
    @(negedge clk);
    chk(!bus_grant && !core_en, "R9 release returns to sleep", {bus_grant, core_en}, 0);
    bus_req = 1'b1;
    @(negedge clk);
    irq_req = 3'b001;
    repeat (2) @(negedge clk);
    chk(bus_grant && !core_en, "R9 irq held off during grant", core_en, 0);
    bus_req = 1'b0;
    wait_wake(n);
    chk(n == 2, "R9 pending wake after release", n, 2);
    irq_req = '0;

    // R10: reset during the count, NMI latch cleared
    restart_cnt = 4'd12;
    go_sleep(1, 1, 0);
    nmi_n = 1'b0;
    @(negedge clk) nmi_n = 1'b1;
    repeat (3) @(negedge clk);
    p0 = npulse;
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk(core_en && clkout_en, "R10 reset during count", {core_en, clkout_en}, 2'b11);
    @(negedge clk);
    chk(npulse == p0, "R10 no pulse on reset", npulse - p0, 0);
    go_sleep(0, 0, 0);
    repeat (6) @(negedge clk);
    chk(!core_en, "R10 nmi latch cleared", core_en, 0);
    do_reset();

    summary();
    $finish;
  end
endmodule